// File: doc/BRIEF.md
# Reference Loss Monitor with Status Selector

This block watches a reference clock for disappearance, with all of its logic clocked by the VCO-side clock. It receives a single-cycle strobe for each reference edge, already synchronized into the VCO domain. It also receives a strobe for each phase-detector cycle and the digital lock indicator. The monitor stays idle until lock has been held without a break for a programmable number of phase-detector cycles. Once armed, a missing reference raises a sticky loss flag and, in the same cycle, a request to put the charge pump into tristate.

The flag and the tristate request hold until software drops the enable input. Dropping the enable clears both outputs and disarms the monitor. Raising the enable again starts a new lock qualification from zero. A 4-bit selector picks what drives the single status output: the flag in either polarity, or the OR of loss-of-lock and loss-of-reference in either polarity.

Top module: `refloss_monitor`

## Requirements
- R1: While reset is asserted and right after it, `loss_flag` and `cp_tristate` are 0 and the monitor is not armed.
- R2: The reference counts as missing once `MISS_CYCLES` (default 64) consecutive clock cycles pass without `ref_edge`. Every `ref_edge` restarts the count. If the monitor is armed, `loss_flag` rises one cycle after the count completes, which is 66 cycles after the cycle in which the last strobe was driven.
- R3: `arm_dly` sets the arming delay in `pfd_tick` cycles with `lock_in` high: 00 gives 3, 01 gives 6, 10 gives 12 and 11 gives 24. The monitor arms on the qualifying tick itself. One tick short of the target never arms it.
- R4: If `lock_in` drops for any cycle before arming completes, the qualification count restarts from zero.
- R5: `loss_flag` and `cp_tristate` rise together. They stay high while `mon_en` is 1, even after reference strobes return.
- R6: `mon_en` = 0 clears `loss_flag` and `cp_tristate` on the next cycle and disarms the monitor. After `mon_en` returns to 1, the full qualification delay is needed again before a loss can be flagged.
- R7: `stat_sel` = 1010 drives `status_out` with `loss_flag`. `stat_sel` = 1111 drives it with the inverse of `loss_flag`.
- R8: `stat_sel` = 1101 drives `status_out` with (NOT `lock_in`) OR `loss_flag`. `stat_sel` = 1110 drives it with the inverse of that value.
- R9: Every other `stat_sel` code drives `status_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-side clock for all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_edge | input | 1 | One-cycle strobe per reference edge, already synchronized |
| pfd_tick | input | 1 | One-cycle strobe per phase-detector cycle |
| lock_in | input | 1 | Digital lock indicator |
| mon_en | input | 1 | Monitor enable; 0 clears the flag and disarms |
| arm_dly | input | 2 | Arming delay code (3/6/12/24 ticks) |
| stat_sel | input | 4 | Status output selector |
| loss_flag | output | 1 | Sticky loss-of-reference flag |
| cp_tristate | output | 1 | Charge-pump tristate request |
| status_out | output | 1 | Selected status signal |

## Verification
The arming state has no port of its own, so the bench measures it through timing. It stops the reference first and then feeds phase-detector ticks one at a time. The flag must stay low until the qualifying tick and must rise exactly two cycles after that tick is driven. With this method, a miscounted delay code or a lock drop that fails to restart the count shows up within a single tick. A miss counter that fails to restart on a strobe raises the flag about 60 cycles too early. A flag that is not sticky, or not cleared by the enable, shows up on the next sampled cycle. The bench also drives every selector code in both flag states and both lock states.

// File: rtl/refloss_monitor.sv
module refloss_monitor #(
  parameter int MISS_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_edge,
  input  logic       pfd_tick,
  input  logic       lock_in,
  input  logic       mon_en,
  input  logic [1:0] arm_dly,
  input  logic [3:0] stat_sel,
  output logic       loss_flag,
  output logic       cp_tristate,
  output logic       status_out
);
  localparam int MW = $clog2(MISS_CYCLES + 1);
  localparam int QW = 5;

  logic [MW-1:0] miss_cnt;
  logic [QW-1:0] qual_cnt;
  logic [QW-1:0] qual_goal;
  logic          armed;
  logic          ref_missing;
  logic          lol_or_lref;

  always_comb begin
    case (arm_dly)
      2'd0:    qual_goal = QW'(3);
      2'd1:    qual_goal = QW'(6);
      2'd2:    qual_goal = QW'(12);
      default: qual_goal = QW'(24);
    endcase
  end

  assign ref_missing = (miss_cnt == MW'(MISS_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           miss_cnt <= '0;
    else if (ref_edge)    miss_cnt <= '0;
    else if (!ref_missing) miss_cnt <= miss_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_cnt <= '0;
      armed    <= 1'b0;
    end else if (!mon_en) begin
      qual_cnt <= '0;
      armed    <= 1'b0;
    end else if (!armed) begin
      if (!lock_in) qual_cnt <= '0;
      else if (pfd_tick) begin
        if (qual_cnt + QW'(1) >= qual_goal) begin
          armed    <= 1'b1;
          qual_cnt <= '0;
        end else begin
          qual_cnt <= qual_cnt + QW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      loss_flag <= 1'b0;
    else if (!mon_en)                loss_flag <= 1'b0;
    else if (armed && ref_missing)   loss_flag <= 1'b1;
  end

  assign cp_tristate = loss_flag;
  assign lol_or_lref = !lock_in || loss_flag;

  always_comb begin
    case (stat_sel)
      4'b1010: status_out = loss_flag;
      4'b1111: status_out = !loss_flag;
      4'b1101: status_out = lol_or_lref;
      4'b1110: status_out = !lol_or_lref;
      default: status_out = 1'b0;
    endcase
  end

  AST_ARM_NEEDS_LOCK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(lock_in && pfd_tick && mon_en)); // R3
  AST_FLAG_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loss_flag) |-> $past(armed && ref_missing)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_flag && mon_en) |=> loss_flag); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> (!loss_flag && !cp_tristate)); // R6
  AST_UNUSED_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_sel inside {4'b1010, 4'b1111, 4'b1101, 4'b1110}) |-> !status_out); // R9
endmodule

// File: tb/refloss_monitor_bench.sv
module refloss_monitor_bench;
  logic clk = 0, rst_n = 0;
  logic ref_edge = 0, pfd_tick = 0, lock_in = 0, mon_en = 0;
  logic [1:0] arm_dly = 0;
  logic [3:0] stat_sel = 4'b1010;
  logic loss_flag, cp_tristate, status_out;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct { int at; int f; int s; string tag; } exp_t;
  exp_t q[$];
  exp_t it;

  always #2.5 clk = ~clk;

  refloss_monitor u_refloss_monitor (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .pfd_tick(pfd_tick),
    .lock_in(lock_in), .mon_en(mon_en), .arm_dly(arm_dly), .stat_sel(stat_sel),
    .loss_flag(loss_flag), .cp_tristate(cp_tristate), .status_out(status_out)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int d, int f, int s, string tag);
    exp_t e;
    e.at = cyc + d; e.f = f; e.s = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(logic r, logic p);
    @(negedge clk);
    ref_edge = r;
    pfd_tick = p;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    while (q.size() > 0 && q[0].at <= cyc) begin
      it = q.pop_front();
      if (it.f >= 0) begin
        chk(it.tag, "loss_flag", loss_flag, it.f[0]);
        chk(it.tag, "cp_tristate", cp_tristate, it.f[0]);
      end
      if (it.s >= 0) chk(it.tag, "status_out", status_out, it.s[0]);
    end
  end

  task automatic sel_check(logic [3:0] sel, logic lk, int s, string tag);
    step(0, 0);
    stat_sel = sel;
    lock_in = lk;
    expect_at(1, -1, s, tag);
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1", "loss_flag in reset", loss_flag, 0);
    chk("R1", "cp_tristate in reset", cp_tristate, 0);
    step(0, 0); rst_n = 1; mon_en = 1; arm_dly = 2'b00;
    for (int i = 0; i < 20; i++) step(i % 4 == 0, i % 2 == 0);
    expect_at(80, 0, 0, "R1 no arm without lock");
    idle(82);

    // R3: delay 01 -> 6 ticks
    step(0, 0); lock_in = 1; arm_dly = 2'b01;
    for (int i = 0; i < 5; i++) step(1, 1);
    expect_at(80, 0, -1, "R3 five ticks not armed");
    idle(82);
    step(0, 1);
    expect_at(1, 0, -1, "R3 sixth tick");
    expect_at(2, 1, 1, "R5 flag and tristate together");
    idle(3);

    for (int i = 0; i < 50; i++) step(1, 0);
    expect_at(1, 1, 1, "R5 sticky with strobes back");
    idle(2);

    sel_check(4'b1111, 1, 0, "R7 inverse flag");
    sel_check(4'b1101, 1, 1, "R8 or flag set");
    sel_check(4'b1110, 1, 0, "R8 inverse or");
    sel_check(4'b0011, 1, 0, "R9 unused code");
    sel_check(4'b0000, 0, 0, "R9 zero code");

    // R6 clear
    step(0, 0); mon_en = 0; stat_sel = 4'b1010;
    expect_at(1, 0, 0, "R6 disable clears");
    idle(2);
    sel_check(4'b1111, 1, 1, "R7 inverse flag clear");
    sel_check(4'b1101, 1, 0, "R8 locked no loss");
    sel_check(4'b1110, 1, 1, "R8 inverse locked");
    sel_check(4'b1101, 0, 1, "R8 lock lost");
    sel_check(4'b1110, 0, 0, "R8 inverse lock lost");

    // R6 re-enable needs requal; R4 lock drop restart (delay 00 -> 3)
    step(0, 0); mon_en = 1; lock_in = 1; arm_dly = 2'b00; stat_sel = 4'b1010;
    step(0, 1); step(0, 1);
    expect_at(80, 0, 0, "R6 re-enabled not armed");
    idle(82);
    step(0, 0); lock_in = 0;
    step(0, 0); lock_in = 1;
    step(0, 1); step(0, 1);
    expect_at(80, 0, -1, "R4 lock drop restarts");
    idle(82);
    step(0, 1);
    expect_at(1, 0, -1, "R4 third tick");
    expect_at(2, 1, -1, "R3 delay 00 arms");
    idle(3);

    // R2 exact miss timing and strobe restart, delay 10 -> 12
    step(0, 0); mon_en = 0;
    step(0, 0); mon_en = 1; arm_dly = 2'b10;
    for (int i = 0; i < 12; i++) step(1, 1);
    idle(60);
    step(1, 0);
    expect_at(65, 0, -1, "R2 strobe restarts count");
    expect_at(66, 1, -1, "R2 flag after timeout");
    idle(68);

    // R3 delay 11 -> 24
    step(0, 0); mon_en = 0;
    step(0, 0); mon_en = 1; arm_dly = 2'b11;
    for (int i = 0; i < 23; i++) step(0, 1);
    expect_at(5, 0, -1, "R3 23 ticks not armed");
    idle(6);
    step(0, 1);
    expect_at(1, 0, -1, "R3 24th tick");
    expect_at(2, 1, -1, "R3 delay 11 arms");
    idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule